// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Programmable Dead Time

This block sits between the two on/off commands that a controller issues for the upper and lower switch of one half bridge and the two gate-enable signals that go to the drive stage. When the interlock is active, it never lets both gates be enabled together. After either gate switches off, it holds the opposite gate off for a dead time chosen by a 3-bit select. That delay starts from the moment the gate actually turns off. It is not a fixed delay added to a command edge.

A static strap input can bypass the interlock so that the two channels behave as independent drivers. A fault input from an upstream fault latch overrides every mode and pulls both gates low. The dead-time cycle counts are computed at elaboration from the clock-frequency parameter, so one select code stands for the same time at any clock rate.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: With `ilBypass` low, `gateTop` and `gateBot` are never high in the same cycle. A channel whose command rises while the opposite gate is on, or still inside its dead time, stays off.
- R2: With `ilBypass` low, when one gate falls while the other command is already high and steady, the other gate rises exactly N clock cycles after the fall. N is the dead-time count for the current `dtSel`.
- R3: The `dtSel` encoding is: 0 = 10 µs (the value when the strap is left at zero), 1 = 0.9 µs, 2 = 1.8 µs, 3 = 2.5 µs, 4 = 3.2 µs, 5 = 4.0 µs, 6 = 5.0 µs, 7 = 7.7 µs. N = round(t × CLK_HZ), with a minimum of 1.
- R4: With `ilBypass` high, each gate follows its own command one clock later, and both gates may be high together.
- R5: When `faultBlock` is high, both gates are low in that same cycle, in every mode including bypass. The gates stay low for the cycle after it as well.
- R6: A command that is high and allowed turns its gate on after one clock edge. A command that drops turns its gate off after one clock edge, with no added delay.
- R7: With `ilBypass` low and both gates off, if both commands are high together, neither gate turns on. When one of the commands drops, the other gate turns on one clock later.
- R8: A command input that is undriven or unknown counts as off.
- R9: While `rstN` is low, both gates are low. After reset no dead time is pending, so the first allowed command turns its gate on after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdTop | input | 1 | Upper switch command, high = on |
| cmdBot | input | 1 | Lower switch command, high = on |
| dtSel | input | 3 | Dead-time select (encoding in R3) |
| ilBypass | input | 1 | High = interlock off, two independent channels |
| faultBlock | input | 1 | Synchronous fault block, high forces both gates low |
| gateTop | output | 1 | Upper gate enable |
| gateBot | output | 1 | Lower gate enable |

## Verification
A dead-time counter that loads the wrong count or decrements wrongly shows up at the ports as a change in the both-low gap between one gate falling and the other rising. The gap is measured to the cycle for every select code and in both directions. A gate register that holds a stale value shows up one edge after a command drops, or in the cycle after a fault. A missing tie rule shows up as a gate rising one edge after both commands rise together. Any overlap of the gates in interlock mode is visible in the very cycle it happens.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  localparam int NCH = 2;   // channel 0 = upper, channel 1 = lower
  localparam int CH_TOP = 0;
  localparam int CH_BOT = 1;
  localparam int NSEL = 8;

  typedef struct packed {
    logic [NCH-1:0] load;   // gate of that channel falls this edge
  } dt_strobe_t;

  // dead time in nanoseconds per select code
  function automatic longint dtNs(input int sel);
    case (sel)
      1:       return 64'd900;
      2:       return 64'd1800;
      3:       return 64'd2500;
      4:       return 64'd3200;
      5:       return 64'd4000;
      6:       return 64'd5000;
      7:       return 64'd7700;
      default: return 64'd10000;
    endcase
  endfunction

  function automatic longint dtCycles(input longint clkHz, input int sel);
    longint c;
    c = (dtNs(sel) * clkHz + 64'd500_000_000) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic longint maxDtCycles(input longint clkHz);
    longint m;
    m = 1;
    for (int s = 0; s < NSEL; s++)
      if (dtCycles(clkHz, s) > m) m = dtCycles(clkHz, s);
    return m;
  endfunction

endpackage

// File: rtl/hb_dt_datapath.sv
module hb_dt_datapath
  import hb_dt_pkg::*;
#(
  parameter longint CLK_HZ = 200_000_000
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [2:0]     dtSel,
  input  dt_strobe_t     strobe,
  output logic [NCH-1:0] busy
);

  localparam longint MAX_CYC = maxDtCycles(CLK_HZ);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] loadLut [NSEL];

  // load value is N-1 so that the opposite gate may rise N edges after the fall
  for (genvar s = 0; s < NSEL; s++) begin : g_lut
    localparam longint CYC = dtCycles(CLK_HZ, s);
    assign loadLut[s] = CNT_W'(CYC - 1);
  end

  logic [CNT_W-1:0] loadVal;
  assign loadVal = loadLut[dtSel];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cnt <= '0;
      else if (strobe.load[ch]) cnt <= loadVal;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
    end
    assign busy[ch] = (cnt != '0);
  end

endmodule

// File: rtl/hb_dt_control.sv
module hb_dt_control
  import hb_dt_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdTop,
  input  logic           cmdBot,
  input  logic           ilBypass,
  input  logic           faultBlock,
  input  logic [NCH-1:0] busy,
  output logic [NCH-1:0] gateQ,
  output dt_strobe_t     strobe
);

  logic [NCH-1:0] cmdOn;
  logic [NCH-1:0] gateNext;

  // only a clean high counts as on; unknown falls to the else branch
  always_comb begin
    if (cmdTop) cmdOn[CH_TOP] = 1'b1;
    else        cmdOn[CH_TOP] = 1'b0;
    if (cmdBot) cmdOn[CH_BOT] = 1'b1;
    else        cmdOn[CH_BOT] = 1'b0;
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (faultBlock)
        gateNext[i] = 1'b0;
      else if (ilBypass)
        gateNext[i] = cmdOn[i];
      else
        gateNext[i] = cmdOn[i]
                    && !gateQ[NCH-1-i]
                    && !busy[NCH-1-i]
                    && (gateQ[i] || !cmdOn[NCH-1-i]);
    end
  end

  always_comb strobe.load = gateQ & ~gateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateQ <= '0;
    else       gateQ <= gateNext;
  end

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_dt_pkg::*;
#(
  parameter longint CLK_HZ = 200_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdTop,
  input  logic       cmdBot,
  input  logic [2:0] dtSel,
  input  logic       ilBypass,
  input  logic       faultBlock,
  output logic       gateTop,
  output logic       gateBot
);

  dt_strobe_t     strobe;
  logic [NCH-1:0] busy;
  logic [NCH-1:0] gateQ;

  hb_dt_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdTop     (cmdTop),
    .cmdBot     (cmdBot),
    .ilBypass   (ilBypass),
    .faultBlock (faultBlock),
    .busy       (busy),
    .gateQ      (gateQ),
    .strobe     (strobe)
  );

  hb_dt_datapath #(.CLK_HZ(CLK_HZ)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .dtSel  (dtSel),
    .strobe (strobe),
    .busy   (busy)
  );

  // fault acts in the same cycle, ahead of the registers
  assign gateTop = gateQ[CH_TOP] && !faultBlock;
  assign gateBot = gateQ[CH_BOT] && !faultBlock;

endmodule

// File: rtl/hb_dt_checker.sv
module hb_dt_checker (
  input logic clk,
  input logic rstN,
  input logic cmdTop,
  input logic cmdBot,
  input logic ilBypass,
  input logic faultBlock,
  input logic gateTop,
  input logic gateBot
);

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    (!ilBypass && !$past(ilBypass)) |-> !(gateTop && gateBot));

  a_r2_bot_rise_after_top_low: assert property (@(posedge clk) disable iff (!rstN)
    (!ilBypass && $rose(gateBot)) |-> !$past(gateTop));

  a_r2_top_rise_after_bot_low: assert property (@(posedge clk) disable iff (!rstN)
    (!ilBypass && $rose(gateTop)) |-> !$past(gateBot));

  a_r4_bypass_follow: assert property (@(posedge clk) disable iff (!rstN)
    (ilBypass && !faultBlock) |=> (faultBlock || !ilBypass ||
                                   (gateTop == $past(cmdTop) && gateBot == $past(cmdBot))));

  a_r5_fault_clears: assert property (@(posedge clk) disable iff (!rstN)
    faultBlock |=> (!gateTop && !gateBot));

  a_r6_drop_top: assert property (@(posedge clk) disable iff (!rstN)
    !cmdTop |=> !gateTop);

  a_r6_drop_bot: assert property (@(posedge clk) disable iff (!rstN)
    !cmdBot |=> !gateBot);

  a_r7_tie_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!ilBypass && !gateTop && !gateBot && cmdTop && cmdBot) |=> (!gateTop && !gateBot));

endmodule

bind hb_deadtime_ctrl hb_dt_checker i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdTop     (cmdTop),
  .cmdBot     (cmdBot),
  .ilBypass   (ilBypass),
  .faultBlock (faultBlock),
  .gateTop    (gateTop),
  .gateBot    (gateBot)
);

// File: tb/test_hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module test_hb_deadtime_ctrl;

  localparam longint TB_CLK_HZ = 10_000_000; // count base, gives small cycle counts

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdTop = 1'b0;
  logic cmdBot = 1'b0;
  logic [2:0] dtSel = 3'd0;
  logic ilBypass = 1'b0;
  logic faultBlock = 1'b0;
  logic gateTop;
  logic gateBot;

  int totalCnt = 0;
  int passCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hb_deadtime_ctrl #(.CLK_HZ(TB_CLK_HZ)) i_hb_deadtime_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdTop     (cmdTop),
    .cmdBot     (cmdBot),
    .dtSel      (dtSel),
    .ilBypass   (ilBypass),
    .faultBlock (faultBlock),
    .gateTop    (gateTop),
    .gateBot    (gateBot)
  );

  function automatic int expGap(input int sel);
    int ns;
    case (sel)
      0: ns = 10000; 1: ns = 900;  2: ns = 1800; 3: ns = 2500;
      4: ns = 3200;  5: ns = 4000; 6: ns = 5000; default: ns = 7700;
    endcase
    return int'((longint'(ns) * TB_CLK_HZ + 64'd500_000_000) / 64'd1_000_000_000);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    totalCnt++;
    if (act == exp) passCnt++;
    else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    cmdTop = 1'b0; cmdBot = 1'b0; faultBlock = 1'b0;
    step(110);
  endtask

  task automatic testReset();
    step(3);
    chk("R9", "gateTop in reset", gateTop, 0);
    chk("R9", "gateBot in reset", gateBot, 0);
    rstN = 1'b1;
    step(1);
    cmdTop = 1'b1;
    #1 chk("R6", "gateTop before edge", gateTop, 0);
    step(1);
    chk("R9", "first on after reset", gateTop, 1);
    cmdTop = 1'b0;
    step(1);
    chk("R6", "drop turns off next edge", gateTop, 0);
    settle();
  endtask

  // first channel on, other waits, first drops: measure both-low gap
  task automatic testGap(input int sel, input bit topFirst);
    int gap;
    dtSel = 3'(sel);
    if (topFirst) cmdTop = 1'b1; else cmdBot = 1'b1;
    step(1);
    if (topFirst) cmdBot = 1'b1; else cmdTop = 1'b1;
    step(5);
    chk("R1", "waiting channel held off", topFirst ? gateBot : gateTop, 0);
    if (topFirst) cmdTop = 1'b0; else cmdBot = 1'b0;
    step(1);
    gap = 0;
    while ((topFirst ? gateBot : gateTop) == 1'b0 && gap < 300) begin
      gap++;
      step(1);
    end
    chk("R2", $sformatf("dead-time gap sel %0d top %0d (R3 code)", sel, topFirst),
        gap, expGap(sel));
    settle();
  endtask

  task automatic testTie();
    dtSel = 3'd1;
    cmdTop = 1'b1; cmdBot = 1'b1;
    step(6);
    chk("R7", "tie keeps top off", gateTop, 0);
    chk("R7", "tie keeps bot off", gateBot, 0);
    cmdBot = 1'b0;
    step(1);
    chk("R7", "top on after bot drops", gateTop, 1);
    settle();
  endtask

  task automatic testBypass();
    ilBypass = 1'b1;
    cmdTop = 1'b1; cmdBot = 1'b1;
    step(1);
    chk("R4", "bypass top follows", gateTop, 1);
    chk("R4", "bypass bot follows", gateBot, 1);
    faultBlock = 1'b1;
    #1;
    chk("R5", "fault drops top same cycle", gateTop, 0);
    chk("R5", "fault drops bot same cycle", gateBot, 0);
    step(1);
    chk("R5", "fault holds gates low", gateTop | gateBot, 0);
    faultBlock = 1'b0;
    step(1);
    chk("R4", "bypass resumes after fault", gateTop & gateBot, 1);
    cmdBot = 1'b0;
    step(1);
    chk("R4", "bypass bot independent", {gateTop, gateBot}, 2);
    cmdTop = 1'b0;
    step(1);
    ilBypass = 1'b0;
    settle();
  endtask

  task automatic testFaultInterlock();
    dtSel = 3'd1;
    cmdTop = 1'b1;
    step(1);
    chk("R6", "top on", gateTop, 1);
    faultBlock = 1'b1;
    #1 chk("R5", "fault drops top interlocked", gateTop, 0);
    step(2);
    chk("R5", "top stays low under fault", gateTop, 0);
    faultBlock = 1'b0;
    step(1);
    chk("R5", "top returns after fault", gateTop, 1);
    settle();
  endtask

  task automatic testUndriven();
    cmdTop = 1'bz;
    cmdBot = 1'bx;
    step(3);
    chk("R8", "undriven top off", gateTop, 0);
    chk("R8", "unknown bot off", gateBot, 0);
    settle();
  endtask

  initial begin
    testReset();
    for (int s = 0; s < 8; s++) testGap(s, 1'b1);
    testGap(1, 1'b0);
    testGap(7, 1'b0);
    testTie();
    testBypass();
    testFaultInterlock();
    testUndriven();
    done = 1'b1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

endmodule